// File: doc/BRIEF.md
# Real-Time Counter with Snapshot, Load and Threshold Alarm

This block keeps a free-running 47-bit counter. The counter advances on every clock where a tick-enable input is high. Software reaches the block through two host-side registers. The first is an address register. The second is a data port that reads or writes whichever internal byte the address register selects.

Behind the data port sit three groups of registers:
- a 48-bit snapshot field, held as six bytes, through which the counter is read or loaded;
- a 48-bit alarm field, also six bytes;
- one control byte.

The counter sits one bit up inside the snapshot field, so its bit 0 appears at field bit 1. The alarm field uses the same layout.

Command bits in the control byte ask for a snapshot of the counter or a load of the counter. Hardware clears each command bit on its own once the transfer has been made. A magnitude comparator raises a sticky alarm flag whenever the counter has reached or passed the alarm value while alarms are enabled. The flag drives a wake line directly, and drives an interrupt line and a reset-request line through their own enable bits.

Top module: `rtc_snap_alarm`

## Requirements
- R1: After reset, every snapshot byte and every alarm byte reads 0xFF, the control byte reads 0x00, and irq, rst_req and wake are low.
- R2: A host write with host_sel=0 loads the address register; a host write with host_sel=1 writes the addressed byte; host_rdata always shows the addressed byte. The map is: snapshot bytes at 0x00..0x05 (least significant byte at 0x00), alarm bytes at 0x08..0x0D, control at 0x0E. Any other address reads 0x00 and ignores writes.
- R3: The counter increments by one on each clock with tick_en high and wraps from all ones to zero.
- R4: Control bit 3 (snapshot command) makes the next clock copy the counter into snapshot field bits 47:1 and clear field bit 0. The command bit reads 0 again after that clock.
- R5: Control bit 4 (load command) makes the next clock load the counter from snapshot field bits 47:1, with priority over a tick. The command bit then reads 0. A write that sets bits 3 and 4 together performs the load only and leaves the snapshot bytes untouched.
- R6: While control bit 0 (alarm enable) is 1, the alarm flag (control bit 5) is set on the clock after the counter becomes greater than or equal to alarm field bits 47:1. Equality fires, one below does not, and an all-ones alarm field cannot be passed.
- R7: The alarm flag stays set until a control write with bit 5 equal to 0. A control write with bit 5 equal to 1 leaves the flag unchanged.
- R8: wake equals the flag; irq equals the flag AND control bit 1; rst_req equals the flag AND control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects the address register, 1 the data port |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Contents of the addressed byte |
| irq | output | 1 | Alarm interrupt request |
| rst_req | output | 1 | Alarm reset request |
| wake | output | 1 | Alarm wake line |

## Verification
The comparator is driven from a table of counter and alarm pairs. The pairs are exact equality, one below, the top of the range, zero against zero, and values that straddle the upper half boundary, where a comparison made only on the low bytes would give the wrong answer. An all-ones alarm is also in the table. Directed sequences separate the counting path from the load path: a plain count and a wrap from all ones, then a combined snapshot-and-load write that shows whether the snapshot was wrongly taken as well. Further sequences cover the shifted placement of the counter inside the snapshot bytes, whether the flag holds or clears under each value of bit 5, and whether an unmapped address really ignores a write.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  // Control byte layout: bits 7:6 read zero, the rest follow this struct (msb first).
  typedef struct packed {
    logic flag;     // bit 5
    logic set_cmd;  // bit 4
    logic cap_cmd;  // bit 3
    logic rst_en;   // bit 2
    logic irq_en;   // bit 1
    logic alm_en;   // bit 0
  } rtc_ctrl_t;

  localparam int CTRL_BITS = $bits(rtc_ctrl_t);
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int W = 47
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  function automatic logic [W-1:0] advance(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (tick_en) count <= advance(count);
  end

  p_tick_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load) |=> (count == $past(count) + W'(1)));
  p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int W = 47
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] timer,
  input  logic [W-1:0] limit,
  input  logic         clr_req,
  output logic         hit,
  output logic         flag
);
  function automatic logic at_or_past(input logic [W-1:0] t, input logic [W-1:0] l);
    return t >= l;
  endfunction

  assign hit = at_or_past(timer, limit);

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag & ~clr_req) | (enable & hit);
  end

  p_flag_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hit) |=> flag);
  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(enable && hit));
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
endmodule

// File: rtl/rtc_snap_alarm.sv
module rtc_snap_alarm
  import rtc_snap_pkg::*;
#(
  parameter int TIMER_W   = 47,
  parameter int ADDR_W    = 8,
  parameter int ALM_BASE  = 8,
  parameter int CTRL_ADDR = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       host_we,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq,
  output logic       rst_req,
  output logic       wake
);
  localparam int NBYTES  = (TIMER_W + 8) / 8;
  localparam int FIELD_W = NBYTES * 8;
  localparam int IDX_W   = $clog2(NBYTES);

  logic [ADDR_W-1:0]        addr_q;
  logic [NBYTES-1:0][7:0]   cap_q, alm_q;
  logic [FIELD_W-1:0]       cap_flat, alm_flat;
  rtc_ctrl_t                ctrl;
  logic [TIMER_W-1:0]       count;
  logic                     alarm_hit, alarm_flag;

  // named decode events
  logic [ADDR_W-1:0] alm_off;
  logic              is_cap, is_alm, is_ctrl, data_wr, ctrl_wr, clr_req;
  logic [IDX_W-1:0]  cap_idx, alm_idx;

  assign alm_off  = addr_q - ADDR_W'(ALM_BASE);
  assign is_cap   = addr_q < ADDR_W'(NBYTES);
  assign is_alm   = alm_off < ADDR_W'(NBYTES);
  assign is_ctrl  = addr_q == ADDR_W'(CTRL_ADDR);
  assign cap_idx  = addr_q[IDX_W-1:0];
  assign alm_idx  = alm_off[IDX_W-1:0];
  assign data_wr  = host_we & host_sel;
  assign ctrl_wr  = data_wr & is_ctrl;
  assign clr_req  = ctrl_wr & ~host_wdata[5];
  assign cap_flat = cap_q;
  assign alm_flat = alm_q;

  function automatic logic [FIELD_W-1:0] to_field(input logic [TIMER_W-1:0] t);
    return FIELD_W'({t, 1'b0});
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (host_we && !host_sel) addr_q <= host_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl.alm_en  <= 1'b0;
      ctrl.irq_en  <= 1'b0;
      ctrl.rst_en  <= 1'b0;
      ctrl.cap_cmd <= 1'b0;
      ctrl.set_cmd <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl.alm_en  <= host_wdata[0];
      ctrl.irq_en  <= host_wdata[1];
      ctrl.rst_en  <= host_wdata[2];
      ctrl.cap_cmd <= host_wdata[3] & ~host_wdata[4];
      ctrl.set_cmd <= host_wdata[4];
    end else begin
      ctrl.cap_cmd <= 1'b0;
      ctrl.set_cmd <= 1'b0;
    end
  end
  assign ctrl.flag = alarm_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) cap_q <= '1;
    else if (ctrl.cap_cmd) cap_q <= to_field(count);
    else if (data_wr && is_cap) cap_q[cap_idx] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) alm_q <= '1;
    else if (data_wr && is_alm) alm_q[alm_idx] <= host_wdata;
  end

  always_comb begin
    if (is_cap)       host_rdata = cap_q[cap_idx];
    else if (is_alm)  host_rdata = alm_q[alm_idx];
    else if (is_ctrl) host_rdata = 8'({ctrl});
    else              host_rdata = 8'h00;
  end

  rtc_counter #(.W(TIMER_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .load(ctrl.set_cmd), .load_val(cap_flat[TIMER_W:1]), .count(count)
  );

  rtc_alarm #(.W(TIMER_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .enable(ctrl.alm_en), .timer(count),
    .limit(alm_flat[TIMER_W:1]), .clr_req(clr_req),
    .hit(alarm_hit), .flag(alarm_flag)
  );

  assign wake    = alarm_flag;
  assign irq     = alarm_flag & ctrl.irq_en;
  assign rst_req = alarm_flag & ctrl.rst_en;

  p_cmd_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.cap_cmd && !ctrl_wr) |=> !ctrl.cap_cmd);
  p_snapshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.cap_cmd |=> (cap_flat[TIMER_W:1] == $past(count) && !cap_flat[0]));
  p_set_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.set_cmd |-> !ctrl.cap_cmd);
  p_out_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || rst_req) |-> wake);
  p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_cap && !is_alm && !is_ctrl) |-> (host_rdata == 8'h00));
endmodule

// File: tb/rtc_snap_alarm_tb.sv
`timescale 1ns/1ps
module rtc_snap_alarm_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic host_we = 1'b0;
  logic host_sel = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic irq, rst_req, wake;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_snap_alarm dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .host_we(host_we),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .rst_req(rst_req), .wake(wake)
  );

  localparam logic [46:0] MAXV = {47{1'b1}};
  localparam logic [46:0] HALF = 47'h4000_0000_0000;
  // {timer, alarm, expected flag}
  localparam logic [94:0] VEC [7] = '{
    {47'd100, 47'd100, 1'b1},
    {47'd99,  47'd100, 1'b0},
    {MAXV,    MAXV,    1'b1},
    {47'd0,   47'd0,   1'b1},
    {HALF,    HALF - 47'd1, 1'b1},
    {HALF - 47'd1, HALF, 1'b0},
    {47'd5,   MAXV,    1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    put(1'b0, a); put(1'b1, d);
  endtask

  task automatic rreg(input logic [7:0] a, output logic [7:0] d);
    put(1'b0, a); d = host_rdata;
  endtask

  task automatic write_field(input logic [7:0] base, input logic [47:0] f);
    for (int i = 0; i < 6; i++) wreg(base + 8'(i), f[i*8 +: 8]);
  endtask

  task automatic read_field(input logic [7:0] base, output logic [47:0] f);
    logic [7:0] b;
    for (int i = 0; i < 6; i++) begin rreg(base + 8'(i), b); f[i*8 +: 8] = b; end
  endtask

  task automatic load_timer(input logic [46:0] v);
    write_field(8'h00, {v, 1'b0});
    wreg(8'h0E, 8'h10);
    @(negedge clk);
  endtask

  task automatic snap(output logic [47:0] f);
    wreg(8'h0E, 8'h08);
    @(negedge clk);
    read_field(8'h00, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [47:0] f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rreg(8'h00, b); check(b == 8'hFF, "R1 snapshot byte0", b, 8'hFF);
    rreg(8'h05, b); check(b == 8'hFF, "R1 snapshot byte5", b, 8'hFF);
    rreg(8'h0D, b); check(b == 8'hFF, "R1 alarm byte5", b, 8'hFF);
    rreg(8'h0E, b); check(b == 8'h00, "R1 control", b, 8'h00);
    check({irq, rst_req, wake} == 3'b000, "R1 outputs", {irq, rst_req, wake}, 0);

    // R6 comparator table
    foreach (VEC[k]) begin
      wreg(8'h0E, 8'h00);
      write_field(8'h08, {VEC[k][47:1], 1'b0});
      load_timer(VEC[k][94:48]);
      wreg(8'h0E, 8'h23);
      @(negedge clk);
      check(irq == VEC[k][0] && wake == VEC[k][0] && !rst_req,
            $sformatf("R6 vector %0d", k), {irq, wake, rst_req}, {VEC[k][0], VEC[k][0], 1'b0});
    end

    // R8, R7 output gating and stickiness
    wreg(8'h0E, 8'h00);
    write_field(8'h08, {47'd40, 1'b0});
    load_timer(47'd50);
    wreg(8'h0E, 8'h27);
    @(negedge clk);
    check({irq, rst_req, wake} == 3'b111, "R8 all outputs", {irq, rst_req, wake}, 3'b111);
    wreg(8'h0E, 8'h22);
    @(negedge clk);
    check(irq && !rst_req && wake, "R8 reset gate off", {irq, rst_req, wake}, 3'b101);
    check(irq, "R7 flag held with bit5=1", irq, 1);
    rreg(8'h0E, b); check(b == 8'h22, "R2 control readback", b, 8'h22);
    wreg(8'h0E, 8'h02);
    @(negedge clk);
    check(!irq && !wake, "R7 flag cleared", {irq, wake}, 0);

    // R3 counting and R4 snapshot placement
    wreg(8'h0E, 8'h00);
    load_timer(47'd10);
    @(negedge clk); tick_en = 1'b1;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    snap(f);
    check(f[47:1] == 47'd15, "R3 count by ticks", f[47:1], 15);
    check(f[7:0] == 8'h1E, "R4 shifted snapshot byte0", f[7:0], 8'h1E);
    rreg(8'h0E, b); check(b[3] == 1'b0, "R4 command self-clear", b, 0);
    load_timer(MAXV);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    snap(f);
    check(f[47:1] == 47'd0, "R3 wrap", f[47:1], 0);

    // R5 load-only when both commands set
    load_timer(47'h123);
    write_field(8'h00, {47'h456, 1'b0});
    wreg(8'h0E, 8'h18);
    @(negedge clk);
    rreg(8'h0E, b); check(b[4:3] == 2'b00, "R5 commands cleared", b, 0);
    read_field(8'h00, f);
    check(f[47:1] == 47'h456, "R5 snapshot untouched", f[47:1], 47'h456);
    snap(f);
    check(f[47:1] == 47'h456, "R5 counter loaded", f[47:1], 47'h456);

    // R2 unmapped addresses
    wreg(8'h07, 8'hAA);
    rreg(8'h07, b); check(b == 8'h00, "R2 unmapped 0x07", b, 0);
    wreg(8'h0F, 8'h55);
    rreg(8'h0F, b); check(b == 8'h00, "R2 unmapped 0x0F", b, 0);
    wreg(8'h09, 8'h3C);
    rreg(8'h09, b); check(b == 8'h3C, "R2 alarm byte write", b, 8'h3C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule